// File: doc/BRIEF.md
# Four-Lane Serial-to-Parallel Converter with Selectable Output Clock

This block takes a retimed serial stream, one bit per rising edge of the recovered bit clock, and gathers it into 4-bit words. Each word is handed to downstream logic on a parallel bus. All four lanes of the bus change together, and this happens once per group of four bit clocks. Word boundaries are fixed by the reset: the first bit clocked in after reset is released opens the first group. No search for a word or frame boundary is made.

Next to the data the block generates a parallel clock for the downstream logic. With the mode input low, this clock runs at one quarter of the bit rate, and its rising edge samples each word. With the mode input high, it runs at one eighth of the bit rate and toggles once per word, so a new word is carried on each of its edges. In both modes, every edge that carries data falls two bit clocks after the word update, which is the middle of the four-clock data interval. A separate reference clock at the word rate is also driven. It does not depend on the mode and can clock the logic that sends data back.

Top module: `quad_deser`

## Requirements
- R1: Within each group of four serial bits, the first bit received appears on `par_data[3]`, the second on `par_data[2]`, the third on `par_data[1]`, and the last on `par_data[0]`.
- R2: `par_data` changes only at the bit-clock edge that samples the fourth bit of a group, and it then holds for four bit clocks. No lane changes at any other edge.
- R3: With `ddr_mode` = 0, `par_clk` has a period of four bit clocks: it is high for two and low for two. Its rising edge comes two bit clocks after each `par_data` update.
- R4: With `ddr_mode` = 1, `par_clk` has a period of eight bit clocks and a 50% duty cycle. It toggles once per word, two bit clocks after each `par_data` update, so no edge of `par_clk` coincides with a data change.
- R5: `ref_clk` has a period of four bit clocks and a 50% duty cycle in both modes. It is high for the same cycles as the single-rate `par_clk`.
- R6: A synchronous reset (`rst` = 1) clears `par_data` to 0, drives `par_clk` and `ref_clk` low, and restarts the grouping. The first bit sampled after `rst` falls becomes the first bit of a new group. After release, both divided clocks first rise at the second bit-clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered bit-rate clock; every bit is sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ddr_mode | input | 1 | 0: parallel clock at bit rate / 4; 1: parallel clock at bit rate / 8 with data on both edges |
| ser_in | input | 1 | Retimed serial data |
| par_data | output | 4 | Parallel word; bit 3 holds the first bit of the group |
| par_clk | output | 1 | Parallel output clock, rate set by `ddr_mode` |
| ref_clk | output | 1 | Word-rate reference clock (bit rate / 4) |

## Verification
The bench streams words whose set bits sit at one end only, alternating patterns and a counting sequence. These catch a reversed lane order or a bit slipped by one position, since either gives a visibly different word. Every cycle it compares both clocks and the data with a phase model counted from reset release. A divider with the wrong phase, an edge that lands on a data change, or a half-rate clock that only toggles every other word would therefore be reported at the first cycle where it differs. A reset applied in the middle of a group checks that the grouping restarts; a design that kept its old bit count would assemble words shifted across the old boundary.

// File: rtl/deser_pkg.sv
package deser_pkg;

  // Output clocks are high while the counter sits in the window that begins
  // halfway through the word, so each rising edge lands mid-interval.
  function automatic logic div_high_next(input int unsigned cnt, input int unsigned w);
    return (cnt >= (w / 2) - 1) && (cnt <= w - 2);
  endfunction

  // The half-rate clock toggles at the same point in every word.
  function automatic logic half_toggle(input int unsigned cnt, input int unsigned w);
    return cnt == (w / 2) - 1;
  endfunction

endpackage

// File: rtl/deser_bitcnt.sv
module deser_bitcnt #(
  parameter int WORD_W = 4,
  localparam int CNT_W = $clog2(WORD_W)
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt,
  output logic             word_strobe
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  always_ff @(posedge clk) begin
    if (rst)                cnt <= '0;
    else if (cnt == LAST)   cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end

  assign word_strobe = !rst && (cnt == LAST);
endmodule

// File: rtl/deser_clkgen.sv
module deser_clkgen
  import deser_pkg::*;
#(
  parameter int WORD_W = 4,
  localparam int CNT_W = $clog2(WORD_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt,
  output logic             word_clk,
  output logic             half_clk
);
  always_ff @(posedge clk) begin
    if (rst) begin
      word_clk <= 1'b0;
      half_clk <= 1'b0;
    end else begin
      word_clk <= div_high_next(int'(cnt), WORD_W);
      half_clk <= half_clk ^ half_toggle(int'(cnt), WORD_W);
    end
  end
endmodule

// File: rtl/deser_shift.sv
module deser_shift #(
  parameter int WORD_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_in,
  input  logic              word_strobe,
  output logic [WORD_W-2:0] shift_q,
  output logic [WORD_W-1:0] word_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q <= '0;
      word_q  <= '0;
    end else begin
      shift_q <= {shift_q[WORD_W-3:0], ser_in};
      if (word_strobe) word_q <= {shift_q, ser_in};
    end
  end
endmodule

// File: rtl/quad_deser.sv
module quad_deser #(
  parameter int WORD_W = 4,
  localparam int CNT_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ddr_mode,
  input  logic              ser_in,
  output logic [WORD_W-1:0] par_data,
  output logic              par_clk,
  output logic              ref_clk
);
  logic [CNT_W-1:0]  bit_cnt;
  logic              word_strobe;
  logic [WORD_W-2:0] shift_q;
  logic              word_clk;
  logic              half_clk;

  deser_bitcnt #(.WORD_W(WORD_W)) u_cnt (
    .clk(clk), .rst(rst), .cnt(bit_cnt), .word_strobe(word_strobe)
  );

  deser_shift #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .ser_in(ser_in), .word_strobe(word_strobe),
    .shift_q(shift_q), .word_q(par_data)
  );

  deser_clkgen #(.WORD_W(WORD_W)) u_clk (
    .clk(clk), .rst(rst), .cnt(bit_cnt),
    .word_clk(word_clk), .half_clk(half_clk)
  );

  assign par_clk = ddr_mode ? half_clk : word_clk;
  assign ref_clk = word_clk;
endmodule

// File: rtl/deser_checker.sv
module deser_checker #(
  parameter int WORD_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              ddr_mode,
  input logic              ser_in,
  input logic [WORD_W-1:0] par_data,
  input logic              par_clk,
  input logic              ref_clk,
  input logic              word_strobe,
  input logic [WORD_W-2:0] shift_q
);
  AST_LANES_ATOMIC: assert property (@(posedge clk) disable iff (rst)
    !$stable(par_data) |-> $past(word_strobe)); // R2
  AST_LSB_LAST: assert property (@(posedge clk) disable iff (rst)
    word_strobe |=> par_data[0] == $past(ser_in)); // R1
  AST_MSB_FIRST: assert property (@(posedge clk) disable iff (rst)
    word_strobe |=> par_data[WORD_W-1] == $past(shift_q[WORD_W-2])); // R1
  AST_SDR_RISE_MID: assert property (@(posedge clk) disable iff (rst)
    (!ddr_mode && $rose(par_clk)) |-> ($stable(par_data) && !$past(word_strobe))); // R3
  AST_DDR_EDGE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (ddr_mode && !$stable(par_clk)) |-> $stable(par_data)); // R4
  AST_REF_HIGH_HOLD: assert property (@(posedge clk) disable iff (rst)
    $rose(ref_clk) |=> ref_clk); // R5
  AST_REF_LOW_HOLD: assert property (@(posedge clk) disable iff (rst)
    $fell(ref_clk) |=> !ref_clk); // R5
endmodule

bind quad_deser deser_checker #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .ddr_mode(ddr_mode), .ser_in(ser_in),
  .par_data(par_data), .par_clk(par_clk), .ref_clk(ref_clk),
  .word_strobe(word_strobe), .shift_q(shift_q)
);

// File: tb/quad_deser_tb.sv
module quad_deser_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ddr_mode = 1'b0;
  logic       ser_in = 1'b0;
  logic [3:0] par_data;
  logic       par_clk;
  logic       ref_clk;

  int checks = 0;
  int errors = 0;
  logic [3:0] exp_q[$];
  bit finished = 0;

  always #2.5 clk = ~clk;

  quad_deser u_dut (
    .clk(clk), .rst(rst), .ddr_mode(ddr_mode), .ser_in(ser_in),
    .par_data(par_data), .par_clk(par_clk), .ref_clk(ref_clk)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Monitor: phase model counted from reset release, data from the scoreboard.
  logic [3:0] cur_exp = 4'h0;
  int k = 0;
  always @(posedge clk) begin
    logic was_rst;
    was_rst = rst;
    #2;
    if (was_rst) begin
      cur_exp = 4'h0;
      k = 0;
      chk("R6 data", par_data, 0);
      chk("R6 par_clk", par_clk, 0);
      chk("R6 ref_clk", ref_clk, 0);
    end else begin
      automatic int ph = k % 4;
      automatic int tog = (k >= 1) ? ((k - 1) / 4 + 1) : 0;
      automatic int ref_exp = (ph == 1 || ph == 2) ? 1 : 0;
      if (ph == 3 && exp_q.size() > 0) cur_exp = exp_q.pop_front();
      chk("R1/R2 data", par_data, cur_exp);
      chk("R5 ref_clk", ref_clk, ref_exp);
      if (ddr_mode) chk("R4 par_clk", par_clk, tog % 2);
      else          chk("R3 par_clk", par_clk, ref_exp);
      k++;
    end
  end

  // Driver: pushes the expected word, then shifts it out first bit first.
  task automatic send_word(input logic [3:0] w);
    exp_q.push_back(w);
    for (int i = 3; i >= 0; i--) begin
      ser_in = w[i];
      @(negedge clk);
    end
  endtask

  task automatic send_bits(input logic [3:0] w, input int n);
    for (int i = 3; i > 3 - n; i--) begin
      ser_in = w[i];
      @(negedge clk);
    end
  endtask

  task automatic do_reset(input logic mode);
    rst = 1'b1;
    exp_q.delete();
    ddr_mode = mode;
    ser_in = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    // R6: reset state checked by the monitor while rst is high
    do_reset(1'b0);
    // R1 R3: single-rate, lane order patterns
    send_word(4'h8); send_word(4'h1); send_word(4'hA); send_word(4'h5);
    send_word(4'hF); send_word(4'h0); send_word(4'hC); send_word(4'h3);
    do_reset(1'b1);
    // R4: dual-rate, both edges
    send_word(4'h4); send_word(4'h2); send_word(4'h9); send_word(4'h6);
    send_word(4'hE); send_word(4'h7);
    // R6: reset in mid-group, grouping restarts
    send_bits(4'hB, 2);
    do_reset(1'b1);
    send_word(4'hD); send_word(4'h1);
    do_reset(1'b0);
    // R2 R5: counting sequence
    for (int v = 0; v < 16; v++) send_word(v[3:0]);
    do_reset(1'b0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule